// File: doc/BRIEF.md
# Tagged operand type router

This block sits in front of the integer and floating-point units of a core that carries dynamic type tags in the top bits of each 64-bit register value. For an arithmetic request it looks at the class bits of both operands and routes the request in one of four ways. A pair of fixnums goes to the integer unit. A pair of flonums goes to the floating-point unit. A mixed fixnum and flonum pair runs as a two-step floating-point sequence that converts first and then operates. Any other class is trapped to software.

The mixed and floating-point paths are run by a small sequencer. Each of its steps raises a request and waits for a done input from the external unit. While the sequencer is busy, new requests are not taken. A floating-point result always leaves the block carrying the flonum tag.

Alongside the router, a set of combinational helpers works on operand A. They give the class and the object sub-kind, a fixnum payload sign-extended to 64 bits, a copy of the value retagged as fixnum, and a masked compare of the upper four tag bits against a pattern.

Top module: `tag_router`

## Requirements
- R1: `cls_o` equals `op_a_i[63:62]`, with the encoding 00 object, 01 fixnum, 10 flonum, 11 other. When the class is 00, `sub_o` encodes `op_a_i[61:60]` as follows: 00 gives 00 (pointer), 01 gives 01 (reserved), and 1x gives 10 (bounded array). For any other class, `sub_o` is 00.
- R2: Suppose a request is taken while idle and both operands have class 01. Then `alu_go_o` is high for exactly the one cycle after the request edge, and `busy_o` stays low.
- R3: Suppose a request is taken while idle and both operands have class 10. Then `fpu_req_o` goes high in the cycle after the request and stays high until an edge where `fpu_done_i` is high. `cvt_req_o` is never raised.
- R4: Suppose a request is taken while idle with one operand of class 01 and the other of class 10. Then `cvt_req_o` goes high in the next cycle. `cvt_sel_o` is 1 if B is the fixnum and 0 if A is, and `cvt_src_o` is that fixnum's payload sign-extended. `cvt_req_o` holds until an edge where `cvt_done_i` is high. `fpu_req_o` then rises in the following cycle.
- R5: Suppose a request is taken while idle and either operand has class 00 or 11. Then `trap_o` is high for the one following cycle, and no unit request is raised.
- R6: In the cycle after the edge where `fpu_done_i` ends the operate step, `result_valid_o` is high for one cycle. `result_o` equals `{2'b10, fpu_result_i[61:0]}`, sampled at that edge.
- R7: While `busy_o` is high, `req_i` is ignored: it raises neither `alu_go_o` nor `trap_o`, and it does not change the sequence in progress.
- R8: `sext_o` equals `op_a_i[61:0]` with bit 61 copied into bits 63:62.
- R9: `fix_tag_o` equals `{2'b01, op_a_i[61:0]}`.
- R10: `match_o` is 1 exactly when `(op_a_i[63:60] ^ pat_i) & mask_i` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Arithmetic request, taken only when idle |
| op_a_i | input | 64 | Tagged operand A |
| op_b_i | input | 64 | Tagged operand B |
| pat_i | input | 4 | Tag pattern for the match helper |
| mask_i | input | 4 | Bit mask for the match helper |
| cvt_done_i | input | 1 | Conversion step finished |
| fpu_done_i | input | 1 | Floating-point operate step finished |
| fpu_result_i | input | 64 | Raw floating-point result |
| alu_go_o | output | 1 | One-cycle integer unit accept |
| trap_o | output | 1 | One-cycle type trap |
| cvt_req_o | output | 1 | Conversion step request |
| cvt_sel_o | output | 1 | Operand being converted (1 = B) |
| cvt_src_o | output | 64 | Sign-extended fixnum to convert |
| fpu_req_o | output | 1 | Floating-point operate request |
| result_valid_o | output | 1 | Retagged result valid |
| result_o | output | 64 | Floating-point result carrying the flonum tag |
| busy_o | output | 1 | Sequencer not idle |
| cls_o | output | 2 | Class of operand A |
| sub_o | output | 2 | Object sub-kind of operand A |
| sext_o | output | 64 | Sign-extended fixnum payload of A |
| fix_tag_o | output | 64 | A retagged as fixnum |
| match_o | output | 1 | Masked tag compare result |

## Verification
The helper outputs are combinational, so the bench reads them a short settle delay after it changes operand A. The routing pulses `alu_go_o` and `trap_o`, and the first sequencer request, come from registers. Each is due in the cycle that follows the clock edge where the request is taken. `result_valid_o` is due in the cycle after the edge where `fpu_done_i` is sampled. The bench drives its inputs on the falling edge and samples on the next falling edge, which puts every check exactly one register stage after its cause. Multi-cycle holds are checked again after extra falling edges during which the done inputs stay low.

// File: rtl/tag_router_pkg.sv
package tag_router_pkg;
  localparam int unsigned CLS_W = 2;
  localparam int unsigned TAG_W = 4;

  typedef enum logic [1:0] {
    CLS_OBJ   = 2'b00,
    CLS_FIX   = 2'b01,
    CLS_FLO   = 2'b10,
    CLS_OTHER = 2'b11
  } tag_cls_e;

  typedef enum logic [1:0] {
    SUB_PTR   = 2'b00,
    SUB_RSVD  = 2'b01,
    SUB_ARRAY = 2'b10
  } obj_sub_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'b00,
    ST_CONVERT = 2'b01,
    ST_OPERATE = 2'b10,
    ST_DONE    = 2'b11
  } route_st_e;
endpackage

// File: rtl/tag_decode.sv
module tag_decode
  import tag_router_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0] val_i,
  output tag_cls_e          cls_o,
  output obj_sub_e          sub_o,
  output logic              is_fix_o,
  output logic              is_flo_o,
  output logic [DATA_W-1:0] sext_o
);
  localparam int unsigned PAY_W = DATA_W - CLS_W;

  logic [PAY_W-1:0] payload;

  assign payload  = val_i[PAY_W-1:0];
  assign cls_o    = tag_cls_e'(val_i[DATA_W-1 -: CLS_W]);
  assign is_fix_o = (cls_o == CLS_FIX);
  assign is_flo_o = (cls_o == CLS_FLO);
  assign sext_o   = {{CLS_W{payload[PAY_W-1]}}, payload};

  always_comb begin
    sub_o = SUB_PTR;
    if (cls_o == CLS_OBJ) begin
      if (val_i[PAY_W-1])    sub_o = SUB_ARRAY;
      else if (val_i[PAY_W-2]) sub_o = SUB_RSVD;
      else                   sub_o = SUB_PTR;
    end
  end
endmodule

// File: rtl/tag_helper.sv
module tag_helper
  import tag_router_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0] val_i,
  input  logic [TAG_W-1:0]  pat_i,
  input  logic [TAG_W-1:0]  mask_i,
  output logic [DATA_W-1:0] fix_tag_o,
  output logic              match_o
);
  localparam int unsigned PAY_W = DATA_W - CLS_W;

  logic [TAG_W-1:0] diff;

  assign fix_tag_o = {CLS_FIX, val_i[PAY_W-1:0]};
  assign diff      = (val_i[DATA_W-1 -: TAG_W] ^ pat_i) & mask_i;
  assign match_o   = (diff == '0);
endmodule

// File: rtl/route_fsm.sv
module route_fsm
  import tag_router_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              fix_a_i,
  input  logic              flo_a_i,
  input  logic              fix_b_i,
  input  logic              flo_b_i,
  input  logic [DATA_W-1:0] sext_a_i,
  input  logic [DATA_W-1:0] sext_b_i,
  input  logic              cvt_done_i,
  input  logic              fpu_done_i,
  input  logic [DATA_W-1:0] fpu_result_i,
  output logic              alu_go_o,
  output logic              trap_o,
  output logic              cvt_req_o,
  output logic              cvt_sel_o,
  output logic [DATA_W-1:0] cvt_src_o,
  output logic              fpu_req_o,
  output logic              result_valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              busy_o
);
  localparam int unsigned PAY_W = DATA_W - CLS_W;

  route_st_e         state_q, state_d;
  logic              take;
  logic              both_fix, both_flo, mixed;
  logic              alu_go_q, trap_q, sel_q;
  logic [DATA_W-1:0] src_q;
  logic [PAY_W-1:0]  res_q;

  assign take     = req_i && (state_q == ST_IDLE);
  assign both_fix = fix_a_i && fix_b_i;
  assign both_flo = flo_a_i && flo_b_i;
  assign mixed    = (fix_a_i && flo_b_i) || (flo_a_i && fix_b_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (take && both_flo)   state_d = ST_OPERATE;
        else if (take && mixed) state_d = ST_CONVERT;
      end
      ST_CONVERT: if (cvt_done_i) state_d = ST_OPERATE;
      ST_OPERATE: if (fpu_done_i) state_d = ST_DONE;
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      alu_go_q <= 1'b0;
      trap_q   <= 1'b0;
      sel_q    <= 1'b0;
      src_q    <= '0;
      res_q    <= '0;
    end else begin
      state_q  <= state_d;
      alu_go_q <= take && both_fix;
      trap_q   <= take && !both_fix && !both_flo && !mixed;
      if (take && mixed) begin
        sel_q <= fix_b_i;
        src_q <= fix_b_i ? sext_b_i : sext_a_i;
      end
      if (state_q == ST_OPERATE && fpu_done_i) res_q <= fpu_result_i[PAY_W-1:0];
    end
  end

  assign alu_go_o       = alu_go_q;
  assign trap_o         = trap_q;
  assign cvt_req_o      = (state_q == ST_CONVERT);
  assign cvt_sel_o      = sel_q;
  assign cvt_src_o      = src_q;
  assign fpu_req_o      = (state_q == ST_OPERATE);
  assign result_valid_o = (state_q == ST_DONE);
  assign result_o       = {CLS_FLO, res_q};
  assign busy_o         = (state_q != ST_IDLE);
endmodule

// File: rtl/tag_router.sv
module tag_router
  import tag_router_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  logic [TAG_W-1:0]  pat_i,
  input  logic [TAG_W-1:0]  mask_i,
  input  logic              cvt_done_i,
  input  logic              fpu_done_i,
  input  logic [DATA_W-1:0] fpu_result_i,
  output logic              alu_go_o,
  output logic              trap_o,
  output logic              cvt_req_o,
  output logic              cvt_sel_o,
  output logic [DATA_W-1:0] cvt_src_o,
  output logic              fpu_req_o,
  output logic              result_valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              busy_o,
  output logic [CLS_W-1:0]  cls_o,
  output logic [1:0]        sub_o,
  output logic [DATA_W-1:0] sext_o,
  output logic [DATA_W-1:0] fix_tag_o,
  output logic              match_o
);
  localparam int unsigned N_OPS = 2;

  logic [DATA_W-1:0] ops     [N_OPS];
  tag_cls_e          cls     [N_OPS];
  obj_sub_e          sub     [N_OPS];
  logic              is_fix  [N_OPS];
  logic              is_flo  [N_OPS];
  logic [DATA_W-1:0] sext    [N_OPS];

  assign ops[0] = op_a_i;
  assign ops[1] = op_b_i;

  for (genvar g = 0; g < N_OPS; g++) begin : g_dec
    tag_decode #(.DATA_W(DATA_W)) u_dec (
      .val_i   (ops[g]),
      .cls_o   (cls[g]),
      .sub_o   (sub[g]),
      .is_fix_o(is_fix[g]),
      .is_flo_o(is_flo[g]),
      .sext_o  (sext[g])
    );
  end

  tag_helper #(.DATA_W(DATA_W)) u_help (
    .val_i    (op_a_i),
    .pat_i    (pat_i),
    .mask_i   (mask_i),
    .fix_tag_o(fix_tag_o),
    .match_o  (match_o)
  );

  route_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_i         (req_i),
    .fix_a_i       (is_fix[0]),
    .flo_a_i       (is_flo[0]),
    .fix_b_i       (is_fix[1]),
    .flo_b_i       (is_flo[1]),
    .sext_a_i      (sext[0]),
    .sext_b_i      (sext[1]),
    .cvt_done_i    (cvt_done_i),
    .fpu_done_i    (fpu_done_i),
    .fpu_result_i  (fpu_result_i),
    .alu_go_o      (alu_go_o),
    .trap_o        (trap_o),
    .cvt_req_o     (cvt_req_o),
    .cvt_sel_o     (cvt_sel_o),
    .cvt_src_o     (cvt_src_o),
    .fpu_req_o     (fpu_req_o),
    .result_valid_o(result_valid_o),
    .result_o      (result_o),
    .busy_o        (busy_o)
  );

  assign cls_o  = cls[0];
  assign sub_o  = sub[0];
  assign sext_o = sext[0];
endmodule

// File: rtl/tag_router_chk.sv
module tag_router_chk #(
  parameter int unsigned DATA_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic [DATA_W-1:0] op_a_i,
  input logic [DATA_W-1:0] op_b_i,
  input logic              cvt_done_i,
  input logic              fpu_done_i,
  input logic              alu_go_o,
  input logic              trap_o,
  input logic              cvt_req_o,
  input logic              fpu_req_o,
  input logic              result_valid_o,
  input logic [DATA_W-1:0] result_o,
  input logic              busy_o
);
  // R2: integer accept only follows an idle request with two fixnums
  assert_alu_src_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alu_go_o |-> $past(req_i && !busy_o && op_a_i[DATA_W-1 -: 2] == 2'b01
                       && op_b_i[DATA_W-1 -: 2] == 2'b01));

  // R5: never a trap together with any unit request
  assert_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({alu_go_o, trap_o, cvt_req_o, fpu_req_o, result_valid_o}));

  // R4: conversion request holds until done
  assert_cvt_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cvt_req_o && !cvt_done_i) |=> cvt_req_o);

  // R4: conversion done leads to the operate step
  assert_cvt_next_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cvt_req_o && cvt_done_i) |=> fpu_req_o);

  // R3: operate request holds until done
  assert_fpu_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fpu_req_o && !fpu_done_i) |=> fpu_req_o);

  // R6: result valid follows operate done and carries the flonum tag
  assert_res_tag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |-> (result_o[DATA_W-1 -: 2] == 2'b10 && $past(fpu_req_o && fpu_done_i)));

  // R7: requests while busy are ignored
  assert_busy_ignore_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && req_i) |=> (!alu_go_o && !trap_o));
endmodule

bind tag_router tag_router_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_i         (req_i),
  .op_a_i        (op_a_i),
  .op_b_i        (op_b_i),
  .cvt_done_i    (cvt_done_i),
  .fpu_done_i    (fpu_done_i),
  .alu_go_o      (alu_go_o),
  .trap_o        (trap_o),
  .cvt_req_o     (cvt_req_o),
  .fpu_req_o     (fpu_req_o),
  .result_valid_o(result_valid_o),
  .result_o      (result_o),
  .busy_o        (busy_o)
);

// File: tb/sim_tag_router.sv
`timescale 1ns/1ps
module sim_tag_router;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [63:0] op_a_i = '0;
  logic [63:0] op_b_i = '0;
  logic [3:0]  pat_i = '0;
  logic [3:0]  mask_i = '0;
  logic        cvt_done_i = 1'b0;
  logic        fpu_done_i = 1'b0;
  logic [63:0] fpu_result_i = '0;
  logic        alu_go_o, trap_o, cvt_req_o, cvt_sel_o, fpu_req_o;
  logic        result_valid_o, busy_o, match_o;
  logic [63:0] cvt_src_o, result_o, sext_o, fix_tag_o;
  logic [1:0]  cls_o, sub_o;

  int n_chk = 0;
  int n_fail = 0;

  tag_router u0 (.*);

  always #5 clk_i = ~clk_i;

  localparam logic [63:0] FIX_POS = 64'h4000_0000_0000_1234;
  localparam logic [63:0] FIX_NEG = 64'h7FFF_FFFF_FFFF_FFF0;
  localparam logic [63:0] FLO_A   = 64'h8123_4567_89AB_CDEF;
  localparam logic [63:0] FLO_B   = 64'hBFF0_0000_0000_0000;
  localparam logic [63:0] OBJ_V   = 64'h2000_0000_0000_0040;
  localparam logic [63:0] OTH_V   = 64'hC000_0000_0000_0001;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [63:0] a, input logic [63:0] b);
    @(negedge clk_i);
    op_a_i = a;
    op_b_i = b;
    req_i  = 1'b1;
    @(negedge clk_i);
    req_i  = 1'b0;
  endtask

  task automatic t_reset;
    check("R2 reset alu_go", 64'(alu_go_o), 64'd0);
    check("R7 reset busy", 64'(busy_o), 64'd0);
    check("R6 reset result_valid", 64'(result_valid_o), 64'd0);
  endtask

  task automatic t_helpers;
    op_a_i = FIX_NEG; pat_i = 4'b0111; mask_i = 4'b1111; #1;
    check("R1 class fix", 64'(cls_o), 64'd1);
    check("R1 sub non-object", 64'(sub_o), 64'd0);
    check("R8 sext negative", sext_o, 64'hFFFF_FFFF_FFFF_FFF0);
    check("R10 match exact", 64'(match_o), 64'd1);
    op_a_i = FIX_POS; #1;
    check("R8 sext positive", sext_o, 64'h0000_0000_0000_1234);
    check("R10 mismatch", 64'(match_o), 64'd0);
    mask_i = 4'b1100; #1;
    check("R10 masked match", 64'(match_o), 64'd1);
    op_a_i = FLO_A; #1;
    check("R9 fix tag", fix_tag_o, 64'h4123_4567_89AB_CDEF);
    check("R1 class flo", 64'(cls_o), 64'd2);
    op_a_i = 64'h0000_0000_0000_0007; #1;
    check("R1 sub pointer", 64'(sub_o), 64'd0);
    op_a_i = 64'h1000_0000_0000_0000; #1;
    check("R1 sub reserved", 64'(sub_o), 64'd1);
    op_a_i = 64'h3000_0000_0000_0000; #1;
    check("R1 sub array", 64'(sub_o), 64'd2);
    op_a_i = OTH_V; #1;
    check("R1 class other", 64'(cls_o), 64'd3);
  endtask

  task automatic t_alu;
    send(FIX_POS, FIX_NEG);
    check("R2 alu_go pulse", 64'(alu_go_o), 64'd1);
    check("R2 no busy", 64'(busy_o), 64'd0);
    check("R2 no fpu", 64'(fpu_req_o), 64'd0);
    @(negedge clk_i);
    check("R2 alu_go one cycle", 64'(alu_go_o), 64'd0);
  endtask

  task automatic t_trap;
    send(OBJ_V, FIX_POS);
    check("R5 trap object", 64'(trap_o), 64'd1);
    check("R5 no alu", 64'(alu_go_o), 64'd0);
    @(negedge clk_i);
    check("R5 trap one cycle", 64'(trap_o), 64'd0);
    send(FLO_A, OTH_V);
    check("R5 trap other", 64'(trap_o), 64'd1);
    check("R5 no cvt", 64'(cvt_req_o), 64'd0);
    check("R5 no fpu", 64'(fpu_req_o), 64'd0);
  endtask

  task automatic t_flo;
    send(FLO_A, FLO_B);
    check("R3 fpu_req", 64'(fpu_req_o), 64'd1);
    check("R3 no cvt", 64'(cvt_req_o), 64'd0);
    @(negedge clk_i);
    @(negedge clk_i);
    check("R3 fpu_req holds", 64'(fpu_req_o), 64'd1);
    fpu_result_i = 64'hFFFF_0000_1111_2222;
    fpu_done_i = 1'b1;
    @(negedge clk_i);
    fpu_done_i = 1'b0;
    fpu_result_i = '0;
    check("R6 result_valid", 64'(result_valid_o), 64'd1);
    check("R6 result retag", result_o, 64'hBFFF_0000_1111_2222);
    check("R3 fpu_req drops", 64'(fpu_req_o), 64'd0);
    @(negedge clk_i);
    check("R6 valid one cycle", 64'(result_valid_o), 64'd0);
    check("R3 idle again", 64'(busy_o), 64'd0);
  endtask

  task automatic t_mixed(input logic b_is_fix);
    if (b_is_fix) send(FLO_A, FIX_NEG);
    else          send(FIX_POS, FLO_B);
    check("R4 cvt_req", 64'(cvt_req_o), 64'd1);
    check("R4 cvt_sel", 64'(cvt_sel_o), 64'(b_is_fix));
    check("R4 cvt_src", cvt_src_o,
          b_is_fix ? 64'hFFFF_FFFF_FFFF_FFF0 : 64'h0000_0000_0000_1234);
    check("R4 no fpu yet", 64'(fpu_req_o), 64'd0);
    // R7: request while busy is ignored
    send(FIX_POS, FIX_POS);
    check("R7 no alu while busy", 64'(alu_go_o), 64'd0);
    check("R7 cvt still held", 64'(cvt_req_o), 64'd1);
    cvt_done_i = 1'b1;
    @(negedge clk_i);
    cvt_done_i = 1'b0;
    check("R4 fpu after cvt", 64'(fpu_req_o), 64'd1);
    check("R4 cvt drops", 64'(cvt_req_o), 64'd0);
    send(OBJ_V, OBJ_V);
    check("R7 no trap while busy", 64'(trap_o), 64'd0);
    check("R7 fpu still held", 64'(fpu_req_o), 64'd1);
    fpu_result_i = 64'h0123_4567_89AB_CDEF;
    fpu_done_i = 1'b1;
    @(negedge clk_i);
    fpu_done_i = 1'b0;
    check("R6 mixed valid", 64'(result_valid_o), 64'd1);
    check("R6 mixed retag", result_o, 64'h8123_4567_89AB_CDEF);
    @(negedge clk_i);
    check("R7 idle after done", 64'(busy_o), 64'd0);
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_helpers();
    t_alu();
    t_trap();
    t_flo();
    t_mixed(1'b1);
    t_mixed(1'b0);
    @(negedge clk_i);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule